// File: doc/BRIEF.md
# Cross-Clock Frequency Ratio Monitor

The block reports how fast a monitored clock runs compared with a reference clock. It gives the result as an unsigned fixed-point word in the reference domain, with INT_BITS integer bits and FRAC_BITS fraction bits. With the defaults that word is 16.16. Each LSB then stands for the reference frequency divided by 65536, which is about 1.53 kHz for a 100 MHz reference. A reading of exactly zero means that the monitored clock is stopped. The two clocks have no fixed phase or frequency relation.

A free-running binary counter in the monitored domain advances on every monitored edge. Its Gray-coded copy crosses into the reference domain through a two-flop synchroniser, where it is converted back to binary. The reference domain runs a window of exactly 2^WIN_LOG2 cycles and takes a snapshot of the synchronised count on the last cycle of each window. The count for one window is the difference between two successive snapshots. That count is shifted left by FRAC_BITS - WIN_LOG2 and saturates at all ones. With the defaults (WIN_LOG2 = FRAC_BITS = 16) the count of edges is itself the 16.16 ratio. The monitored domain is reset from the reference reset, which is asserted asynchronously and released in step with the monitored clock.

The reference-domain controller has three states:
- ST_IDLE is the state right after reset. It clears the window counter and loads the baseline count. Transition T_START moves it to ST_COUNT.
- ST_COUNT advances the window. On the last window cycle, transition T_WIN_END takes the snapshot and moves to ST_CALC.
- ST_CALC lasts one cycle. It writes the new ratio and moves the baseline. Transition T_RESUME returns to ST_COUNT.

Any reset returns the controller to ST_IDLE.

Top module: `clk_ratio_mon`

## Requirements
- R1: While the reference reset is high, and after it is released until the first evaluation, ratio_o reads 0.
- R2: If the monitored clock makes no edge during a whole window, the next evaluation sets ratio_o to exactly 0.
- R3: ratio_o changes only in the cycle that follows ST_CALC and holds its value at every other time.
- R4: The monitored count crosses into the reference domain as a Gray code. Its value changes in at most one bit per monitored edge.
- R5: Evaluations are spaced exactly 2^WIN_LOG2 reference cycles apart. ST_CALC always follows the last window cycle and lasts one cycle.
- R6: The reading equals the number of monitored edges in the window shifted left by FRAC_BITS - WIN_LOG2. This is f_mon/f_ref in unsigned INT_BITS.FRAC_BITS format, within one count of quantisation.
- R7: When the edge count reaches 2^(INT_BITS+WIN_LOG2) or more, ratio_o saturates to all ones.
- R8: After a stopped monitored clock starts again, the reading returns to the correct ratio within three windows, without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all outputs are in this domain |
| ref_rst | input | 1 | Active-high reset, synchronous to ref_clk; also resets the monitored domain |
| mon_clk | input | 1 | Clock under measurement, asynchronous to ref_clk |
| ratio_o | output | INT_BITS+FRAC_BITS | f_mon/f_ref in unsigned fixed point; 0 means the monitored clock is stopped |

## Verification
The bench builds the block with WIN_LOG2 = 6, INT_BITS = 2 and FRAC_BITS = 8. A window then lasts only 64 reference cycles, and the edge count is shifted left by two. The 10-bit output saturates once the monitored clock runs at four times the reference rate. This puts a sweep of monitored periods within a short run: from 1/8 of the reference rate, through non-integer ratios, up to two settings past saturation. The bench also stops and restarts the monitored clock. It checks the exact 64-cycle spacing of the updates while the count moves between two neighbouring values.

// File: rtl/clk_ratio_mon_pkg.sv
package clk_ratio_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_CALC  = 2'd2
    } mon_state_e;

endpackage

// File: rtl/clk_ratio_mon_rst_sync.sv
// Reset bridge into the monitored domain: asserts at once, releases after
// two monitored edges.
module clk_ratio_mon_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_async,
    output logic rst_sync
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/clk_ratio_mon_gray_cnt.sv
// Free-running edge counter in the monitored domain with a registered Gray copy.
module clk_ratio_mon_gray_cnt #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] gray_o
);
    logic [WIDTH-1:0] bin_q;
    logic [WIDTH-1:0] bin_nx;

    assign bin_nx = bin_q + WIDTH'(1);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/clk_ratio_mon_gray_sync.sv
// Two-flop capture of a Gray word in the destination domain, then back to binary.
module clk_ratio_mon_gray_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] gray_i,
    output logic [WIDTH-1:0] bin_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= gray_i;
            stable_q <= meta_q;
        end
    end

    // Prefix XOR from the top bit down.
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_g2b
            assign bin_o[b] = ^stable_q[WIDTH-1:b];
        end
    endgenerate
endmodule

// File: rtl/clk_ratio_mon.sv
module clk_ratio_mon
    import clk_ratio_mon_pkg::*;
#(
    parameter int WIN_LOG2  = 16,
    parameter int INT_BITS  = 16,
    parameter int FRAC_BITS = 16
) (
    input  logic                          ref_clk,
    input  logic                          ref_rst,
    input  logic                          mon_clk,
    output logic [INT_BITS+FRAC_BITS-1:0] ratio_o
);
    localparam int OUT_W    = INT_BITS + FRAC_BITS;
    localparam int SAT_BIT  = INT_BITS + WIN_LOG2;
    localparam int CNT_W    = SAT_BIT + 2;
    localparam int SHIFT    = FRAC_BITS - WIN_LOG2;
    localparam int SCALED_W = CNT_W + SHIFT;

    logic                mon_rst;
    logic [CNT_W-1:0]    mon_gray;
    logic [CNT_W-1:0]    cur_bin;

    mon_state_e          state_q, state_d;
    logic [WIN_LOG2-1:0] win_q;
    logic [CNT_W-1:0]    prev_q;
    logic [CNT_W-1:0]    snap_q;
    logic [CNT_W-1:0]    delta;
    logic [SCALED_W-1:0] scaled;
    logic                win_last;

    clk_ratio_mon_rst_sync #(.STAGES(2)) u_rst_sync (
        .clk       (mon_clk),
        .rst_async (ref_rst),
        .rst_sync  (mon_rst)
    );

    clk_ratio_mon_gray_cnt #(.WIDTH(CNT_W)) u_mon_cnt (
        .clk    (mon_clk),
        .rst    (mon_rst),
        .gray_o (mon_gray)
    );

    clk_ratio_mon_gray_sync #(.WIDTH(CNT_W)) u_cdc (
        .clk    (ref_clk),
        .rst    (ref_rst),
        .gray_i (mon_gray),
        .bin_o  (cur_bin)
    );

    assign win_last = (win_q == '1);
    assign delta    = snap_q - prev_q;
    assign scaled   = SCALED_W'(delta) << SHIFT;

    // State register
    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_COUNT;
            ST_COUNT: if (win_last) state_d = ST_CALC;
            ST_CALC:  state_d = ST_COUNT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath and output
    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            win_q   <= '0;
            prev_q  <= '0;
            snap_q  <= '0;
            ratio_o <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    win_q  <= '0;
                    prev_q <= cur_bin;
                end
                ST_COUNT: begin
                    win_q <= win_q + WIN_LOG2'(1);
                    if (win_last) begin
                        snap_q <= cur_bin;
                    end
                end
                ST_CALC: begin
                    win_q  <= win_q + WIN_LOG2'(1);
                    prev_q <= snap_q;
                    if (delta == '0) begin
                        ratio_o <= '0;
                    end else if (delta[CNT_W-1:SAT_BIT] != '0) begin
                        ratio_o <= '1;
                    end else begin
                        ratio_o <= scaled[OUT_W-1:0];
                    end
                end
                default: begin
                    win_q <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/clk_ratio_mon_chk.sv
module clk_ratio_mon_chk
    import clk_ratio_mon_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    parameter int CNT_W    = 34,
    parameter int OUT_W    = 32
) (
    input logic                ref_clk,
    input logic                ref_rst,
    input logic                mon_clk,
    input logic                mon_rst,
    input mon_state_e          state_q,
    input logic [WIN_LOG2-1:0] win_q,
    input logic [CNT_W-1:0]    snap_q,
    input logic [CNT_W-1:0]    prev_q,
    input logic [CNT_W-1:0]    mon_gray,
    input logic [OUT_W-1:0]    ratio_o
);
    assert_held_in_reset_R1: assert property (@(posedge ref_clk)
        ref_rst |=> (ratio_o == '0));

    assert_dead_clock_zero_R2: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (state_q == ST_CALC && snap_q == prev_q) |=> (ratio_o == '0));

    assert_hold_between_updates_R3: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (state_q != ST_CALC) |=> $stable(ratio_o));

    assert_gray_single_step_R4: assert property (@(posedge mon_clk) disable iff (mon_rst)
        $countones(mon_gray ^ $past(mon_gray)) <= 1);

    assert_window_end_to_calc_R5: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (state_q == ST_COUNT && win_q == '1) |=> (state_q == ST_CALC));

    assert_calc_single_cycle_R5: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (state_q == ST_CALC) |=> (state_q == ST_COUNT));
endmodule

bind clk_ratio_mon clk_ratio_mon_chk #(
    .WIN_LOG2 (WIN_LOG2),
    .CNT_W    (CNT_W),
    .OUT_W    (OUT_W)
) chk_i (
    .ref_clk  (ref_clk),
    .ref_rst  (ref_rst),
    .mon_clk  (mon_clk),
    .mon_rst  (mon_rst),
    .state_q  (state_q),
    .win_q    (win_q),
    .snap_q   (snap_q),
    .prev_q   (prev_q),
    .mon_gray (mon_gray),
    .ratio_o  (ratio_o)
);

// File: tb/clk_ratio_mon_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_mon_tb_top;
    localparam int WIN  = 6;
    localparam int INTB = 2;
    localparam int FRAC = 8;
    localparam int OW   = INTB + FRAC;
    localparam int WLEN = 1 << WIN;
    localparam real REF_PER = 5.0;

    logic          ref_clk = 1'b0;
    logic          ref_rst = 1'b0;
    logic          mon_clk = 1'b0;
    logic [OW-1:0] ratio_o;
    logic          mon_run = 1'b1;
    real           mon_half = 5.0;
    int            n_chk = 0;
    int            n_fail = 0;
    int            cyc = 0;
    bit            done = 1'b0;

    clk_ratio_mon #(.WIN_LOG2(WIN), .INT_BITS(INTB), .FRAC_BITS(FRAC)) dut_i (
        .ref_clk (ref_clk),
        .ref_rst (ref_rst),
        .mon_clk (mon_clk),
        .ratio_o (ratio_o)
    );

    always #2.5 ref_clk = ~ref_clk;

    always begin
        #(mon_half);
        if (mon_run) mon_clk = ~mon_clk;
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge ref_clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
            report();
        end
    end

    task automatic chk_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge ref_clk);
    endtask

    // R6 / R7: expected reading from the period, checked within one count.
    task automatic chk_period(real per, string req);
        real exp_cnt;
        real act_cnt;
        int  sat;
        mon_half = per / 2.0;
        wait_cyc(3 * WLEN);
        exp_cnt = (WLEN * REF_PER) / per;
        sat = (1 << OW) - 1;
        n_chk++;
        if (exp_cnt >= real'(1 << (INTB + WIN)) + 2.0) begin
            if (int'(ratio_o) != sat) begin
                n_fail++;
                $display("FAIL %s period %0.3f: actual %0d expected %0d", req, per, ratio_o, sat);
            end
        end else begin
            act_cnt = real'(ratio_o) / real'(1 << (FRAC - WIN));
            if (act_cnt - exp_cnt > 1.25 || exp_cnt - act_cnt > 1.25) begin
                n_fail++;
                $display("FAIL %s period %0.3f: actual %0d expected %0.1f", req, per, ratio_o,
                         exp_cnt * real'(1 << (FRAC - WIN)));
            end
        end
    endtask

    initial begin
        int last_i;
        int bad;
        int changes;
        logic [OW-1:0] last_v;
        #1 ref_rst = 1'b1;
        wait_cyc(10);
        chk_eq("R1 during reset", int'(ratio_o), 0);
        ref_rst = 1'b0;
        wait_cyc(WLEN / 2);
        chk_eq("R1 before first evaluation", int'(ratio_o), 0);

        // Sweep over the monitored period, ns.
        chk_period(40.0, "R6");
        chk_period(20.0, "R6");
        chk_period(13.0, "R6");
        chk_period(10.0, "R6");
        chk_period(7.0,  "R6");
        chk_period(5.0,  "R6");
        chk_period(3.3,  "R6");
        chk_period(2.5,  "R6");
        chk_period(1.6,  "R6 R4 fast crossing");
        chk_period(1.0,  "R7");
        chk_period(0.8,  "R7");

        // R3 / R5: updates only on 64-cycle boundaries while the count dithers.
        mon_half = 3.3 / 2.0;
        wait_cyc(3 * WLEN);
        last_v = ratio_o;
        last_i = -1;
        bad = 0;
        changes = 0;
        for (int i = 0; i < 8 * WLEN; i++) begin
            @(negedge ref_clk);
            if (ratio_o != last_v) begin
                changes++;
                if (last_i >= 0 && ((i - last_i) % WLEN) != 0) bad++;
                last_i = i;
                last_v = ratio_o;
            end
        end
        chk_eq("R3 R5 off-boundary updates", bad, 0);
        n_chk++;
        if (changes < 2) begin
            n_fail++;
            $display("FAIL R5: actual %0d changes expected at least 2", changes);
        end

        // R2: stopped clock.
        mon_run = 1'b0;
        wait_cyc(3 * WLEN);
        chk_eq("R2 stopped clock", int'(ratio_o), 0);
        wait_cyc(WLEN / 3);
        chk_eq("R2 stopped clock held", int'(ratio_o), 0);

        // R8: restart without reset.
        mon_run = 1'b1;
        chk_period(10.0, "R8");

        // R1: reset while running.
        @(negedge ref_clk);
        ref_rst = 1'b1;
        wait_cyc(2);
        chk_eq("R1 reset while running", int'(ratio_o), 0);
        ref_rst = 1'b0;
        chk_period(4.0, "R8 after reset");

        done = 1'b1;
        report();
    end
endmodule